// File: doc/BRIEF.md
# Variable-Length Instruction Boundary Detector

This block sits in an instruction fetch path and splits a big-endian stream of 16-bit parcels into instructions. It reads only the first parcel of each instruction, which holds the first two bytes in stream order, with the earlier byte in bits 15:8. From that parcel it decides whether the instruction is 16, 32, 48 or 64 bits long, or whether it opens a variable-length block. It then reports the class, the parcel address where the instruction starts and that leading parcel. After that it drops the instruction's parcels and moves its pointer to the next boundary.

A variable-length block is not sized here. When the detector meets one, it reports the block's class, then raises a handoff flag and waits. An outside agent supplies the block's total length in parcels. The detector then discards that many parcels, counting the header parcel, and resumes classifying at the parcel that follows. A synchronous flush drops any partly received instruction and restarts the pointer at a supplied parcel address.

Top module: `vlen_boundary_detector`

## Requirements
- R1: A leading parcel whose bits 15:10 (the major opcode) are not all zero is reported as class 0 (32-bit), spans 2 parcels, and the pointer advances by 2.
- R2: With bits 15:10 zero and bits 9:8 equal to 00, the class is 1 (16-bit compressed), spanning 1 parcel.
- R3: With bits 15:10 zero and bits 9:8 equal to 01, the class is 2 (48-bit), spanning 3 parcels.
- R4: With bits 15:10 zero and bits 9:8 equal to 10, the class is 3 (64-bit), spanning 4 parcels.
- R5: With bits 15:10 zero and bits 9:8 equal to 11, the class is 4 (variable-length block). Bit 7 and the lower bits of the leading parcel never change the class.
- R6: `out_valid` stays low until every parcel of the instruction is held. Once raised, it stays high with stable class, start and leading parcel until `out_ready` accepts it.
- R7: `out_start` is the parcel address of the instruction's first parcel. Each accepted non-block instruction moves it forward by that instruction's parcel count.
- R8: After a block is accepted, `handoff` is high and `out_valid` is low until `ext_len_valid` is seen. Then `ext_len` parcels (0 is taken as 1), header included, are discarded, and `out_start` advances by that amount.
- R9: Synchronous reset empties the detector, clears `handoff` and `out_valid`, and sets `out_start` to the START_ADDR parameter.
- R10: `flush` drops every held parcel, cancels a pending handoff, and on the next cycle sets `out_start` to `flush_addr`. While `flush` is high, `in_ready` and `out_valid` are low.
- R11: Up to four parcels are held, and `in_ready` is low while four are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Drop held parcels and realign the pointer |
| flush_addr | input | ADDR_W | Parcel address loaded on flush |
| in_valid | input | 1 | Incoming parcel is valid |
| in_ready | output | 1 | Detector can take a parcel |
| in_parcel | input | 16 | Incoming parcel, earlier byte in bits 15:8 |
| out_valid | output | 1 | A classified instruction is presented |
| out_ready | input | 1 | Consumer accepts the classification |
| out_cls | output | 3 | Class: 0=32, 1=16, 2=48, 3=64, 4=block |
| out_start | output | ADDR_W | Parcel address of the instruction start |
| out_first | output | 16 | Leading parcel of the instruction |
| handoff | output | 1 | Waiting for the external block length |
| ext_len_valid | input | 1 | `ext_len` is valid |
| ext_len | input | EXT_W | Block length in parcels, header included |

## Verification
The bench targets the sub-bit boundaries of the zero-opcode row, a major opcode of 1, and a set bit 7 that must not change the class. A decoder that read the wrong bits would report the wrong class and put every later boundary in the wrong place. It holds back the last parcel of a 64-bit instruction, which a design that emits early would report with a wrong leading parcel. It also sends blocks of length three and zero, where a design that skipped the wrong count would leave the next instruction's parcel misaligned. A flush in mid-instruction and a full four-parcel window under backpressure check that the pointer restarts at the given address and that no parcel is lost or duplicated.

// File: rtl/vlen_boundary_detector.sv
module vlen_boundary_detector #(
  parameter int ADDR_W = 32,
  parameter int EXT_W = 8,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_parcel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_cls,
  output logic [ADDR_W-1:0] out_start,
  output logic [15:0]       out_first,
  output logic              handoff,
  input  logic              ext_len_valid,
  input  logic [EXT_W-1:0]  ext_len
);
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [2:0] CLS_32 = 3'd0, CLS_16 = 3'd1, CLS_48 = 3'd2,
                         CLS_64 = 3'd3, CLS_BLK = 3'd4;

  typedef enum logic [1:0] {ST_RUN, ST_WAIT, ST_SKIP} st_t;

  st_t               st;
  logic [15:0]       pbuf [DEPTH];
  logic [15:0]       nbuf [DEPTH];
  logic [CW-1:0]     cnt, len, pop, rem;
  logic [ADDR_W-1:0] ptr;
  logic [EXT_W-1:0]  skip, eff_len;
  logic              push, fire;

  always_comb begin
    if (pbuf[0][15:10] != 6'd0) begin
      out_cls = CLS_32; len = CW'(2);
    end else begin
      case (pbuf[0][9:8])
        2'b00:   begin out_cls = CLS_16;  len = CW'(1); end
        2'b01:   begin out_cls = CLS_48;  len = CW'(3); end
        2'b10:   begin out_cls = CLS_64;  len = CW'(4); end
        default: begin out_cls = CLS_BLK; len = CW'(1); end
      endcase
    end
  end

  assign out_first = pbuf[0];
  assign out_start = ptr;
  assign handoff   = (st == ST_WAIT);
  assign out_valid = !flush && st == ST_RUN && cnt >= len;
  assign fire      = out_valid && out_ready;
  assign in_ready  = !flush && cnt < CW'(DEPTH);
  assign push      = in_valid && in_ready;
  assign eff_len   = (ext_len == '0) ? EXT_W'(1) : ext_len;

  always_comb begin
    pop = '0;
    if (fire && out_cls != CLS_BLK) pop = len;
    else if (st == ST_SKIP && cnt != '0) pop = CW'(1);
  end

  assign rem = cnt - pop;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int j;
      j = i + int'(pop);
      nbuf[i] = (j < DEPTH) ? pbuf[j[IW-1:0]] : pbuf[i];
      if (push && rem == CW'(i)) nbuf[i] = in_parcel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt  <= '0;
      st   <= ST_RUN;
      skip <= '0;
      ptr  <= rst ? START_ADDR : flush_addr;
    end else begin
      pbuf <= nbuf;
      cnt  <= rem + CW'(push);
      case (st)
        ST_RUN: if (fire) begin
          if (out_cls == CLS_BLK) st <= ST_WAIT;
          else ptr <= ptr + ADDR_W'(len);
        end
        ST_WAIT: if (ext_len_valid) begin
          skip <= eff_len;
          ptr  <= ptr + ADDR_W'(eff_len);
          st   <= ST_SKIP;
        end
        default: if (pop != '0) begin
          skip <= skip - EXT_W'(1);
          if (skip == EXT_W'(1)) st <= ST_RUN;
        end
      endcase
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> flush || (out_valid && $stable(out_cls) &&
      $stable(out_start) && $stable(out_first)));

  assert_advance_R7: assert property (@(posedge clk) disable iff (rst)
    fire && out_cls != CLS_BLK && !flush |=>
      out_start == $past(out_start) + ADDR_W'($past(len)));

  assert_handoff_R8: assert property (@(posedge clk) disable iff (rst)
    fire && out_cls == CLS_BLK && !flush |=> handoff && !out_valid);

  assert_wait_R8: assert property (@(posedge clk) disable iff (rst)
    handoff && !ext_len_valid && !flush |=> handoff && $stable(out_start));

  assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> out_start == $past(flush_addr) && !handoff);

  assert_window_R11: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: tb/vlen_boundary_detector_tb.sv
module vlen_boundary_detector_tb;
  localparam logic [31:0] START = 32'h0000_0100;

  logic clk = 0, rst = 1, flush = 0;
  logic [31:0] flush_addr = '0;
  logic in_valid = 0, in_ready;
  logic [15:0] in_parcel = '0;
  logic out_valid, out_ready = 0;
  logic [2:0] out_cls;
  logic [31:0] out_start;
  logic [15:0] out_first;
  logic handoff, ext_len_valid = 0;
  logic [7:0] ext_len = '0;

  vlen_boundary_detector #(.ADDR_W(32), .EXT_W(8), .START_ADDR(START)) u_dut (
    .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_parcel(in_parcel),
    .out_valid(out_valid), .out_ready(out_ready), .out_cls(out_cls),
    .out_start(out_start), .out_first(out_first), .handoff(handoff),
    .ext_len_valid(ext_len_valid), .ext_len(ext_len));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, mcyc = 0;
  bit stall_out = 0, done = 0;
  logic [31:0] exp_addr = START;
  logic [2:0]  q_cls[$];
  logic [31:0] q_start[$];
  logic [15:0] q_first[$];
  logic [7:0]  q_blk[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic put(input logic [15:0] p);
    @(negedge clk);
    in_valid = 1; in_parcel = p;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic send(input logic [2:0] c, input logic [15:0] p0, input int n,
                      input logic [7:0] blen);
    q_cls.push_back(c); q_start.push_back(exp_addr); q_first.push_back(p0);
    if (c == 3'd4) begin
      q_blk.push_back(blen);
      exp_addr += (blen == 0) ? 1 : 32'(blen);
    end else exp_addr += 32'(n);
    put(p0);
    for (int k = 1; k < n; k++) put(p0 ^ 16'(k * 16'h1111));
  endtask

  task automatic drain();
    int t = 0;
    while ((q_cls.size() != 0 || handoff) && t < 500) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (rst) out_ready = 0;
    else begin
      out_ready = !stall_out && (mcyc % 3 != 2);
      mcyc++;
      #1;
      if (out_valid && out_ready) begin
        if (q_cls.size() == 0) check(0, "R6", "unexpected output", 32'(out_cls), 0);
        else begin
          logic [2:0] c; logic [31:0] s; logic [15:0] f;
          c = q_cls.pop_front(); s = q_start.pop_front(); f = q_first.pop_front();
          check(out_cls == c, req_of(c), "class", 32'(out_cls), 32'(c));
          check(out_start == s, "R7/R8", "start", out_start, s);
          check(out_first == f, "R6", "leading parcel", 32'(out_first), 32'(f));
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && handoff && !ext_len_valid) begin
      #2;
      check(!out_valid, "R8", "out_valid during handoff", 32'(out_valid), 0);
      repeat (2) @(negedge clk);
      check(handoff, "R8", "handoff held", 32'(handoff), 1);
      if (q_blk.size() == 0) check(0, "R8", "no block length queued", 0, 1);
      else begin
        ext_len = q_blk.pop_front(); ext_len_valid = 1;
        @(negedge clk);
        ext_len_valid = 0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_start == START, "R9", "reset start", out_start, START);
    check(!out_valid, "R9", "reset out_valid", 32'(out_valid), 0);
    check(!handoff, "R9", "reset handoff", 32'(handoff), 0);
    @(negedge clk); rst = 0;
    #1;
    check(in_ready, "R9", "in_ready after reset", 32'(in_ready), 1);

    send(3'd0, 16'h7C00, 2, 0);   // R1
    send(3'd1, 16'h0055, 1, 0);   // R2
    send(3'd2, 16'h0155, 3, 0);   // R3
    send(3'd3, 16'h02AA, 4, 0);   // R4
    send(3'd1, 16'h00FF, 1, 0);   // R5 bit 7 ignored
    send(3'd0, 16'h0400, 2, 0);   // R1 major opcode 1
    send(3'd2, 16'h0180, 3, 0);   // R3 with bit 7 set
    send(3'd4, 16'h0301, 3, 8'd3); // R5 R8 block of 3
    send(3'd1, 16'h0011, 1, 0);
    send(3'd4, 16'h0380, 1, 8'd0); // R8 zero length taken as 1
    send(3'd3, 16'h0200, 4, 0);
    send(3'd0, 16'hFC01, 2, 0);
    drain();

    // R6: partial 64-bit instruction is held
    put(16'h0233);
    repeat (5) @(negedge clk);
    #2;
    check(!out_valid, "R6", "partial instruction output", 32'(out_valid), 0);
    q_cls.push_back(3'd3); q_start.push_back(exp_addr); q_first.push_back(16'h0233);
    exp_addr += 4;
    put(16'h1000); put(16'h2000); put(16'h3000);
    drain();

    // R11: four parcels fill the window
    stall_out = 1;
    send(3'd0, 16'h4000, 2, 0);
    send(3'd0, 16'h4400, 2, 0);
    repeat (3) @(negedge clk);
    #2;
    check(!in_ready, "R11", "in_ready with full window", 32'(in_ready), 0);
    stall_out = 0;
    drain();

    // R10: flush mid-instruction
    put(16'h8000);
    @(negedge clk);
    flush = 1; flush_addr = 32'h0000_1000;
    #1;
    check(!in_ready && !out_valid, "R10", "ready/valid during flush",
          32'({in_ready, out_valid}), 0);
    @(negedge clk);
    flush = 0;
    #1;
    check(out_start == 32'h1000, "R10", "start after flush", out_start, 32'h1000);
    check(!out_valid, "R10", "partial dropped", 32'(out_valid), 0);
    exp_addr = 32'h1000;
    send(3'd1, 16'h0022, 1, 0);
    send(3'd0, 16'h5000, 2, 0);
    drain();

    check(q_cls.size() == 0, "R6", "items left", 32'(q_cls.size()), 0);
    done = 1;
    finish_run();
  end
endmodule